// File: doc/BRIEF.md
# Trap Handler Target Selector

This block sits in the trap path of a processor core. When a trap is about to be taken, it looks at the current trap level, the mode bits, the trap number and the two trap table base registers. From these it decides which mode will run the handler and where that handler starts. There are four possible outcomes: a trap into the privileged kernel, a trap into the hypervisor, entry into the reset/error/debug (RED) mode, or an error condition when the trap stack is already full.

The caller pulses `req_valid` with the trap context on the inputs. One clock later the block presents, with a one-cycle `rsp_valid` strobe, the following results:
- the route code;
- the handler address;
- the address of the instruction after it;
- a flag that tells the state-save logic which global-level ceiling to apply.

These results then hold until the next request. Saving the trap state and redirecting fetch are done by the neighbouring units.

Top module: `trap_target_sel`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `rsp_valid`, `route`, `hnd_pc`, `hnd_npc` and `gl_hyper_cap` are all zero.
- R2: `rsp_valid` is high for exactly the one cycle after a cycle with `req_valid` high. Without a request, all result outputs keep their values whatever the other inputs do.
- R3: When `red_in` is set, or the trap level equals MAX_TL-1, the route is 2 (RED) and the handler address is 0xFFF00000A0. This case takes priority over every other case, including a full trap stack.
- R4: When R3 does not apply and the trap level equals MAX_TL, the route is 3 (error), and `hnd_pc` and `hnd_npc` are both zero.
- R5: The current mode is hypervisor when `hpriv_in` is set, else kernel when `priv_in` is set, else user. The target mode is kernel from user, and hypervisor from kernel or hypervisor. A hypervisor target gives route 1.
- R6: Suppose the target is kernel and the trap level exceeds MAX_PTL. Then the route is 1 and the vector uses trap number 2 instead of `tt_in`.
- R7: Suppose the target is kernel and `tt_in` is 384 or larger. Then the route is 1 (hypervisor).
- R8: A route-1 handler address is (`htba_in` with bits 13:0 cleared) OR (trap number × 32, kept to bits 13:0).
- R9: A route-0 handler address is built in three parts, which are ORed together. The first is `tba_in` with bits 14:0 cleared. The second is bit 14, which is set when the trap level plus one is greater than 1. The third is `tt_in` × 32, kept to bits 13:0.
- R10: For routes 0, 1 and 2, `hnd_npc` equals `hnd_pc` + 4.
- R11: `gl_hyper_cap` is 1 for routes 1 and 2 and 0 for routes 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request strobe |
| tl_in | input | TL_W | Current trap level |
| hpriv_in | input | 1 | Hypervisor mode bit |
| priv_in | input | 1 | Kernel mode bit |
| red_in | input | 1 | RED mode bit |
| tt_in | input | TT_W | Trap number |
| tba_in | input | ADDR_W | Kernel trap table base |
| htba_in | input | ADDR_W | Hypervisor trap table base |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| route | output | 2 | 0 kernel, 1 hypervisor, 2 RED, 3 error |
| hnd_pc | output | ADDR_W | Handler address |
| hnd_npc | output | ADDR_W | Handler next address |
| gl_hyper_cap | output | 1 | Use the hypervisor global-level ceiling |

## Verification
A fault in the priority decision would show as a wrong route code and a base from the wrong table. That error appears on the single response cycle after the offending request. The vectors therefore sit on each boundary: trap level MAX_PTL against MAX_PTL+1, MAX_TL-1 against MAX_TL, and trap number 383 against 384.

A fault in the masking would flip the bits at 13 and 14 of the handler address. A stuck or missing clock enable would show on the cycles between requests: either a value that changes without a request, or a strobe that lasts more than one cycle.

// File: rtl/trap_target_pkg.sv
package trap_target_pkg;
  typedef enum logic [1:0] {
    RT_PRIV  = 2'd0,
    RT_HYPER = 2'd1,
    RT_RED   = 2'd2,
    RT_ERROR = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    LV_USER  = 2'd0,
    LV_PRIV  = 2'd1,
    LV_HYPER = 2'd2
  } level_e;

  localparam int unsigned WATCHDOG_TT = 2;
  localparam int unsigned RED_TT      = 5;
  localparam int unsigned HYPER_TT_MIN = 384;
endpackage

// File: rtl/trap_route_dec.sv
module trap_route_dec
  import trap_target_pkg::*;
#(
  parameter int unsigned TL_W    = 3,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic [TL_W-1:0] tl,
  input  logic            hpriv,
  input  logic            priv,
  input  logic            red,
  input  logic [TT_W-1:0] tt,
  output route_e          rt,
  output logic [TT_W-1:0] eff_tt,
  output logic            deep_lvl
);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_FULL = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_WD   = TT_W'(WATCHDOG_TT);
  localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYPER_TT_MIN);

  level_e cur_lv;
  level_e tgt_lv;

  always_comb begin
    if (hpriv)     cur_lv = LV_HYPER;
    else if (priv) cur_lv = LV_PRIV;
    else           cur_lv = LV_USER;
  end

  always_comb begin
    tgt_lv = (cur_lv == LV_USER) ? LV_PRIV : LV_HYPER;
  end

  always_comb begin
    eff_tt = tt;
    if (red || tl == TL_RED) begin
      rt = RT_RED;
    end else if (tl == TL_FULL) begin
      rt = RT_ERROR;
    end else if (tl > TL_PMAX && tgt_lv == LV_PRIV) begin
      rt     = RT_HYPER;
      eff_tt = TT_WD;
    end else if (tgt_lv == LV_HYPER || tt >= TT_HMIN) begin
      rt = RT_HYPER;
    end else begin
      rt = RT_PRIV;
    end
  end

  // new trap level (tl + 1) greater than 1 means tl is not zero
  assign deep_lvl = (tl != '0);
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_target_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned TT_W     = 9,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  route_e            rt,
  input  logic [TT_W-1:0]   eff_tt,
  input  logic              deep_lvl,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc
);
  localparam int unsigned HOFF_BITS = 14;
  localparam int unsigned POFF_BITS = 15;
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HOFF_MASK = (ONE << HOFF_BITS) - ONE;
  localparam logic [ADDR_W-1:0] POFF_MASK = (ONE << POFF_BITS) - ONE;
  localparam logic [ADDR_W-1:0] DEEP_BIT  = ONE << HOFF_BITS;
  localparam logic [ADDR_W-1:0] RED_OFF   = ADDR_W'((RED_TT << 5) & 8'hFF);
  localparam logic [ADDR_W-1:0] INSN_B    = ADDR_W'(4);

  logic [ADDR_W-1:0] tt_off;
  logic [ADDR_W-1:0] hyp_pc;
  logic [ADDR_W-1:0] prv_pc;
  logic [ADDR_W-1:0] red_pc;

  assign tt_off = ADDR_W'({eff_tt, 5'b00000}) & HOFF_MASK;
  assign hyp_pc = (htba & ~HOFF_MASK) | tt_off;
  assign prv_pc = (tba & ~POFF_MASK) | (deep_lvl ? DEEP_BIT : '0) | tt_off;
  assign red_pc = ADDR_W'(RED_BASE) | RED_OFF;

  always_comb begin
    unique case (rt)
      RT_RED:   pc = red_pc;
      RT_HYPER: pc = hyp_pc;
      RT_PRIV:  pc = prv_pc;
      default:  pc = '0;
    endcase
    npc = (rt == RT_ERROR) ? '0 : pc + INSN_B;
  end
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel
  import trap_target_pkg::*;
#(
  parameter int unsigned TL_W    = 3,
  parameter int unsigned TT_W    = 9,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TL_W-1:0]   tl_in,
  input  logic              hpriv_in,
  input  logic              priv_in,
  input  logic              red_in,
  input  logic [TT_W-1:0]   tt_in,
  input  logic [ADDR_W-1:0] tba_in,
  input  logic [ADDR_W-1:0] htba_in,
  output logic              rsp_valid,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] hnd_pc,
  output logic [ADDR_W-1:0] hnd_npc,
  output logic              gl_hyper_cap
);
  route_e            c_rt;
  logic [TT_W-1:0]   c_tt;
  logic              c_deep;
  logic [ADDR_W-1:0] c_pc;
  logic [ADDR_W-1:0] c_npc;

  trap_route_dec #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_dec (
    .tl(tl_in), .hpriv(hpriv_in), .priv(priv_in), .red(red_in), .tt(tt_in),
    .rt(c_rt), .eff_tt(c_tt), .deep_lvl(c_deep)
  );

  trap_vector_gen #(
    .ADDR_W(ADDR_W), .TT_W(TT_W)
  ) u_vec (
    .rt(c_rt), .eff_tt(c_tt), .deep_lvl(c_deep), .tba(tba_in), .htba(htba_in),
    .pc(c_pc), .npc(c_npc)
  );

  logic              vld_q, vld_d;
  logic [1:0]        rt_q, rt_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] npc_q, npc_d;
  logic              cap_q, cap_d;

  always_comb begin
    vld_d = req_valid;
    rt_d  = rt_q;
    pc_d  = pc_q;
    npc_d = npc_q;
    cap_d = cap_q;
    if (req_valid) begin
      rt_d  = c_rt;
      pc_d  = c_pc;
      npc_d = c_npc;
      cap_d = (c_rt == RT_HYPER) || (c_rt == RT_RED);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rt_q  <= '0;
      pc_q  <= '0;
      npc_q <= '0;
      cap_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      rt_q  <= rt_d;
      pc_q  <= pc_d;
      npc_q <= npc_d;
      cap_q <= cap_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign route        = rt_q;
  assign hnd_pc       = pc_q;
  assign hnd_npc      = npc_q;
  assign gl_hyper_cap = cap_q;

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> ($stable(hnd_pc) && $stable(route) && $stable(gl_hyper_cap)));
  a_r10_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && route != 2'd3) |-> (hnd_npc == hnd_pc + ADDR_W'(4)));
  a_r4_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'd3) |-> (hnd_pc == '0 && hnd_npc == '0));
  a_r11_cap: assert property (@(posedge clk) disable iff (!rst_n)
    gl_hyper_cap == (route == 2'd1 || route == 2'd2));
  a_r3_red_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && red_in) |=> (route == 2'd2));
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (hnd_pc[4:0] == 5'd0));
endmodule

// File: tb/trap_target_sel_bench.sv
module trap_target_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [63:0] TBA  = 64'h0000_00AB_CDEF_FFFF;
  localparam logic [63:0] HTBA = 64'h0000_0012_3456_FFFF;

  typedef struct packed {
    logic [2:0]  tl;
    logic        hp;
    logic        pv;
    logic        rd;
    logic [8:0]  tt;
    logic [1:0]  rt;
    logic [63:0] pc;
    logic        cap;
  } vec_t;

  // R3 R4 R5 R6 R7 R8 R9 R11 exercised by these rows
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 9'h024, 2'd0, 64'h0000_00AB_CDEF_8480, 1'b0}, // R9 shallow
    '{3'd1, 1'b0, 1'b0, 1'b0, 9'h024, 2'd0, 64'h0000_00AB_CDEF_C480, 1'b0}, // R9 bit14
    '{3'd2, 1'b0, 1'b1, 1'b0, 9'h010, 2'd1, 64'h0000_0012_3456_C200, 1'b1}, // R5 priv->hyper
    '{3'd3, 1'b0, 1'b0, 1'b0, 9'h024, 2'd1, 64'h0000_0012_3456_C040, 1'b1}, // R6 watchdog
    '{3'd1, 1'b0, 1'b0, 1'b0, 9'h180, 2'd1, 64'h0000_0012_3456_F000, 1'b1}, // R7 384
    '{3'd1, 1'b0, 1'b0, 1'b0, 9'h17F, 2'd0, 64'h0000_00AB_CDEF_EFE0, 1'b0}, // R7 383
    '{3'd5, 1'b0, 1'b0, 1'b0, 9'h024, 2'd2, 64'h0000_00FF_F000_00A0, 1'b1}, // R3 tl max-1
    '{3'd0, 1'b1, 1'b0, 1'b1, 9'h010, 2'd2, 64'h0000_00FF_F000_00A0, 1'b1}, // R3 red bit
    '{3'd6, 1'b1, 1'b0, 1'b0, 9'h010, 2'd3, 64'h0000_0000_0000_0000, 1'b0}, // R4 full
    '{3'd6, 1'b0, 1'b0, 1'b1, 9'h010, 2'd2, 64'h0000_00FF_F000_00A0, 1'b1}, // R3 beats R4
    '{3'd2, 1'b0, 1'b0, 1'b0, 9'h1FF, 2'd1, 64'h0000_0012_3456_FFE0, 1'b1}, // R8 top tt
    '{3'd2, 1'b0, 1'b0, 1'b0, 9'h040, 2'd0, 64'h0000_00AB_CDEF_C800, 1'b0}, // R9 at PTL
    '{3'd0, 1'b1, 1'b0, 1'b0, 9'h005, 2'd1, 64'h0000_0012_3456_C0A0, 1'b1}  // R5 hyper
  };

  logic        clk, rst_n, req_valid, hpriv_in, priv_in, red_in;
  logic [2:0]  tl_in;
  logic [8:0]  tt_in;
  logic [63:0] tba_in, htba_in;
  logic        rsp_valid, gl_hyper_cap;
  logic [1:0]  route;
  logic [63:0] hnd_pc, hnd_npc;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  trap_target_sel u_trap_target_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tl_in(tl_in),
    .hpriv_in(hpriv_in), .priv_in(priv_in), .red_in(red_in), .tt_in(tt_in),
    .tba_in(tba_in), .htba_in(htba_in), .rsp_valid(rsp_valid), .route(route),
    .hnd_pc(hnd_pc), .hnd_npc(hnd_npc), .gl_hyper_cap(gl_hyper_cap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      done = 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    tl_in = v.tl; hpriv_in = v.hp; priv_in = v.pv; red_in = v.rd; tt_in = v.tt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; tl_in = '0; hpriv_in = 1'b0; priv_in = 1'b0;
    red_in = 1'b0; tt_in = '0; tba_in = TBA; htba_in = HTBA;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 pc in reset", hnd_pc, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 route after reset", 64'(route), 64'd0);
    chk("R1 npc after reset", hnd_npc, 64'd0);
    chk("R1 cap after reset", 64'(gl_hyper_cap), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk("R2 strobe", 64'(rsp_valid), 64'd1);
      chk("R5 route", 64'(route), 64'(VEC[i].rt));
      chk("R8/R9 handler pc", hnd_pc, VEC[i].pc);
      chk("R10 next pc", hnd_npc, (VEC[i].rt == 2'd3) ? 64'd0 : VEC[i].pc + 64'd4);
      chk("R11 cap", 64'(gl_hyper_cap), 64'(VEC[i].cap));
    end

    // R2: inputs change without a request; results hold, strobe gone
    drive(VEC[0]);
    tl_in = 3'd5; red_in = 1'b1; tt_in = 9'h1FF; htba_in = '0; tba_in = '0;
    @(negedge clk);
    chk("R2 strobe one cycle", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk("R2 hold pc", hnd_pc, VEC[0].pc);
    chk("R2 hold route", 64'(route), 64'd0);
    tba_in = TBA; htba_in = HTBA;

    // R6: watchdog redirect from kernel mode does not apply (target hyper, own tt)
    drive('{3'd4, 1'b0, 1'b1, 1'b0, 9'h030, 2'd1, 64'h0000_0012_3456_C600, 1'b1});
    chk("R6 priv source keeps tt", hnd_pc, 64'h0000_0012_3456_C600);

    // R1: reset mid-run clears results
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async clear pc", hnd_pc, 64'd0);
    chk("R1 async clear route", 64'(route), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule